// File: doc/BRIEF.md
# Interrupt Event Set/Clear Register

This block gathers the interrupt sources of a bridge controller into one 32-bit event register that software reaches through a small register port. Four host-port channel lines, one general-purpose peripheral line and a general-purpose interface error line each latch their event bit on a rising edge. Two GPIO pins latch their event bits on an edge type chosen separately for each pin. Each latched bit then stays set until software clears it.

Software sets latchable bits by writing ones at the set offset and clears them by writing ones at the clear offset. Reading the set offset returns the raw events. Reading the clear offset returns the events ANDed with the interrupt mask. One bit holds no state: it shows, at all times, whether any bit of a host-port error report vector is set. A mask register enables the events, and one registered interrupt output goes high while any enabled event is pending.

Top module: `irq_event_regs`

## Requirements
- R1: Bits 3:0 (host-port channels 0 to 3), bit 26 (peripheral interrupt) and bit 29 (interface error) latch to 1 on the clock edge at which their source is 1 after being 0 on the previous edge. A source held high does not set its bit again.
- R2: A write at offset 0x00 sets each latchable bit (3:0, 29:26) whose data bit is 1. Data bits of 0 have no effect.
- R3: A write at offset 0x04 clears each latched bit whose data bit is 1. Data bits of 0 have no effect. No other action clears a latched bit, and a source that stays high does not set a cleared bit again.
- R4: A source edge in the same cycle as a clear write of that bit leaves the bit set.
- R5: A read at offset 0x00 returns the raw event word. A read at offset 0x04 returns the event word ANDed with the mask. Read data is registered and shows the value for the address presented one clock earlier.
- R6: Bits 31 and 25:4 read as 0 at every offset, even after all-ones writes. Any offset other than 0x00, 0x04 or 0x08 reads as 0.
- R7: Bit 30 equals the OR of all bits of `hp_err_vec` at the read edge. Writes at 0x00 and 0x04 do not change it.
- R8: Bit 27 is the event for GPIO pin 0 and bit 28 is the event for pin 1. The type for pin i is `gpio_evt_type[2i+1:2i]`: 00 rising edge, 01 falling edge, 10 either edge, 11 never. No event latches while `gpio_irq_en[i]` is 0.
- R9: The mask register is read and written at offset 0x08. Only bits 30:26 and 3:0 are stored; all other bits read 0.
- R10: `irq_out` is 1 on the clock after the one at which (event word AND mask) is nonzero, and 0 otherwise.
- R11: After reset, the event register, the mask, the read data and `irq_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| hp_irq | input | 4 | Host-port channel interrupt lines |
| gp_irq | input | 1 | Peripheral interrupt line |
| gp_err | input | 1 | Interface error line |
| gpio_pin | input | GPIO_N | GPIO pin levels |
| gpio_irq_en | input | GPIO_N | Per-pin enable for use as an interrupt input |
| gpio_evt_type | input | 2*GPIO_N | Per-pin edge type selection |
| hp_err_vec | input | ERR_W | Host-port error report vector |
| irq_out | output | 1 | Registered interrupt request |

## Verification
The assertions assume that every source line and GPIO pin is already synchronous to `clk` and held low during reset, so that the first edge seen after reset is a real transition. They also assume that the write strobe lasts one cycle per access. The bench drives all inputs on the falling edge, holds sources at 0 while reset is active, and makes random sources change only now and then. This gives single-cycle pulses, long high levels and edges that coincide with clear writes. Random writes go to all four word offsets, and random mask values keep both masked and unmasked pending states in use.

// File: rtl/irq_evt_pkg.sv
package irq_evt_pkg;
  localparam int DW = 32;
  localparam int HP_CH = 4;
  localparam int OFS_SET  = 'h0;
  localparam int OFS_CLR  = 'h4;
  localparam int OFS_MASK = 'h8;
  localparam int B_GPINT  = 26;
  localparam int B_GPIO0  = 27;
  localparam int B_GPERR  = 29;
  localparam int B_HPERR  = 30;
  localparam logic [DW-1:0] LATCH_BITS = 32'h3C00_000F;
  localparam logic [DW-1:0] MASK_BITS  = 32'h7C00_000F;

  typedef enum logic [1:0] {
    EV_RISE = 2'b00,
    EV_FALL = 2'b01,
    EV_BOTH = 2'b10,
    EV_OFF  = 2'b11
  } gpio_evt_e;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] src,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= RST_VAL;
    else     prev_q <= src;
  end

  assign rise = src & ~prev_q;
endmodule

// File: rtl/irq_gpio_evt.sv
module irq_gpio_evt
  import irq_evt_pkg::*;
#(
  parameter int N = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N-1:0]   pin,
  input  logic [N-1:0]   en,
  input  logic [2*N-1:0] etype,
  output logic [N-1:0]   evt
);
  logic [N-1:0] rise_v;
  logic [N-1:0] fall_v;

  irq_edge_det #(.W(N), .RST_VAL('0)) u_rise (
    .clk(clk), .rst(rst), .src(pin), .rise(rise_v)
  );

  irq_edge_det #(.W(N), .RST_VAL({N{1'b1}})) u_fall (
    .clk(clk), .rst(rst), .src(~pin), .rise(fall_v)
  );

  for (genvar i = 0; i < N; i++) begin : g_pin
    gpio_evt_e kind;
    assign kind = gpio_evt_e'(etype[2*i+1:2*i]);

    always_comb begin
      evt[i] = 1'b0;
      if (en[i]) begin
        case (kind)
          EV_RISE: evt[i] = rise_v[i];
          EV_FALL: evt[i] = fall_v[i];
          EV_BOTH: evt[i] = rise_v[i] | fall_v[i];
          default: evt[i] = 1'b0;
        endcase
      end
    end

    a_r8_no_evt_when_off: assert property (@(posedge clk) disable iff (rst)
      (!en[i] || kind == EV_OFF) |-> !evt[i]);
  end
endmodule

// File: rtl/irq_evt_bank.sv
module irq_evt_bank
  import irq_evt_pkg::*;
#(
  parameter int W = DW,
  parameter logic [W-1:0] LMASK = LATCH_BITS
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  input  logic [W-1:0] hw_vec,
  output logic [W-1:0] ev_q
);
  logic [W-1:0] ev_d;

  always_comb begin
    ev_d = ((ev_q & ~clr_vec) | set_vec | hw_vec) & LMASK;
  end

  always_ff @(posedge clk) begin
    if (rst) ev_q <= '0;
    else     ev_q <= ev_d;
  end

  a_r1_edge_sets: assert property (@(posedge clk) disable iff (rst)
    (|(hw_vec & LMASK)) |=> ((ev_q & $past(hw_vec & LMASK)) == $past(hw_vec & LMASK)));

  a_r4_edge_beats_clear: assert property (@(posedge clk) disable iff (rst)
    (|(hw_vec & clr_vec & LMASK)) |=>
      ((ev_q & $past(hw_vec & clr_vec & LMASK)) == $past(hw_vec & clr_vec & LMASK)));

  a_r3_clear_works: assert property (@(posedge clk) disable iff (rst)
    (|(clr_vec & ~hw_vec & ~set_vec)) |=>
      ((ev_q & $past(clr_vec & ~hw_vec & ~set_vec)) == '0));

  a_r3_only_clear_drops: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((ev_q & $past(ev_q & ~clr_vec)) == $past(ev_q & ~clr_vec)));
endmodule

// File: rtl/irq_event_regs.sv
module irq_event_regs
  import irq_evt_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int GPIO_N = 2,
  parameter int ERR_W  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic [DW-1:0]       bus_wdata,
  output logic [DW-1:0]       bus_rdata,
  input  logic [HP_CH-1:0]    hp_irq,
  input  logic                gp_irq,
  input  logic                gp_err,
  input  logic [GPIO_N-1:0]   gpio_pin,
  input  logic [GPIO_N-1:0]   gpio_irq_en,
  input  logic [2*GPIO_N-1:0] gpio_evt_type,
  input  logic [ERR_W-1:0]    hp_err_vec,
  output logic                irq_out
);
  localparam int NSRC = HP_CH + 2;
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(OFS_SET);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLR);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);

  logic [NSRC-1:0]   src_rise;
  logic [GPIO_N-1:0] gpio_hit;
  logic [DW-1:0]     hw_vec, set_vec, clr_vec, ev_q, ev_full;
  logic [DW-1:0]     mask_q, rdata_d, rdata_q;
  logic              hit_set, hit_clr, hit_mask, hp_err_any, irq_q;

  irq_edge_det #(.W(NSRC), .RST_VAL('0)) u_src_edge (
    .clk(clk), .rst(rst), .src({gp_err, gp_irq, hp_irq}), .rise(src_rise)
  );

  irq_gpio_evt #(.N(GPIO_N)) u_gpio (
    .clk(clk), .rst(rst), .pin(gpio_pin), .en(gpio_irq_en),
    .etype(gpio_evt_type), .evt(gpio_hit)
  );

  always_comb begin
    hw_vec = '0;
    hw_vec[HP_CH-1:0] = src_rise[HP_CH-1:0];
    hw_vec[B_GPINT]   = src_rise[HP_CH];
    hw_vec[B_GPERR]   = src_rise[HP_CH+1];
    for (int i = 0; i < GPIO_N; i++) hw_vec[B_GPIO0+i] = gpio_hit[i];
  end

  assign hit_set  = bus_wr && (bus_addr == A_SET);
  assign hit_clr  = bus_wr && (bus_addr == A_CLR);
  assign hit_mask = bus_wr && (bus_addr == A_MASK);
  assign set_vec  = hit_set ? (bus_wdata & LATCH_BITS) : '0;
  assign clr_vec  = hit_clr ? (bus_wdata & LATCH_BITS) : '0;

  irq_evt_bank #(.W(DW), .LMASK(LATCH_BITS)) u_bank (
    .clk(clk), .rst(rst), .set_vec(set_vec), .clr_vec(clr_vec),
    .hw_vec(hw_vec), .ev_q(ev_q)
  );

  assign hp_err_any = |hp_err_vec;

  always_comb begin
    ev_full = ev_q;
    ev_full[B_HPERR] = hp_err_any;
  end

  always_ff @(posedge clk) begin
    if (rst)           mask_q <= '0;
    else if (hit_mask) mask_q <= bus_wdata & MASK_BITS;
  end

  always_comb begin
    if (bus_addr == A_SET)       rdata_d = ev_full;
    else if (bus_addr == A_CLR)  rdata_d = ev_full & mask_q;
    else if (bus_addr == A_MASK) rdata_d = mask_q;
    else                         rdata_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      irq_q   <= |(ev_full & mask_q);
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_out   = irq_q;

  a_r6_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> (bus_rdata[31] == 1'b0 && bus_rdata[25:4] == '0));

  a_r9_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) |=> !irq_out);

  a_r7_live_error: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == A_SET) |=> (bus_rdata[B_HPERR] == $past(|hp_err_vec)));
endmodule

// File: tb/sim_irq_event_regs.sv
module sim_irq_event_regs;
  localparam logic [31:0] LM = 32'h3C00_000F;
  localparam logic [31:0] MM = 32'h7C00_000F;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  hp_irq = '0;
  logic        gp_irq = 1'b0, gp_err = 1'b0;
  logic [1:0]  gpio_pin = '0, gpio_irq_en = '0;
  logic [3:0]  gpio_evt_type = '0;
  logic [7:0]  hp_err_vec = '0;
  logic        irq_out;

  int tests = 0, fails = 0;
  bit done = 0;

  // next input values, applied by cyc()
  logic [3:0] n_hp = '0; logic n_gp = 0, n_ge = 0;
  logic [1:0] n_pin = '0, n_en = '0; logic [3:0] n_typ = '0; logic [7:0] n_err = '0;

  // reference model state
  logic [31:0] m_ev = '0, m_mask = '0;
  logic [3:0] p_hp = '0; logic p_gp = 0, p_ge = 0; logic [1:0] p_pin = '0;

  irq_event_regs u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hp_irq(hp_irq),
    .gp_irq(gp_irq), .gp_err(gp_err), .gpio_pin(gpio_pin),
    .gpio_irq_en(gpio_irq_en), .gpio_evt_type(gpio_evt_type),
    .hp_err_vec(hp_err_vec), .irq_out(irq_out)
  );

  always #4 clk = ~clk;

  function automatic logic [31:0] full_ev(logic [7:0] err);
    logic [31:0] f = m_ev;
    f[30] = |err;
    return f;
  endfunction

  function automatic logic [31:0] model_read(logic [3:0] a, logic [7:0] err);
    if (a == 4'h0) return full_ev(err);
    if (a == 4'h4) return full_ev(err) & m_mask;
    if (a == 4'h8) return m_mask;
    return 32'h0;
  endfunction

  function automatic logic gpio_fire(logic pv, logic cv, logic en, logic [1:0] t);
    logic r = cv & ~pv, f = ~cv & pv;
    if (!en) return 1'b0;
    case (t)
      2'b00: return r;
      2'b01: return f;
      2'b10: return r | f;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic wr, input logic [3:0] a, input logic [31:0] d);
    logic [31:0] exp_rd, hw, setv, clrv;
    logic exp_irq;
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d;
    hp_irq = n_hp; gp_irq = n_gp; gp_err = n_ge; gpio_pin = n_pin;
    gpio_irq_en = n_en; gpio_evt_type = n_typ; hp_err_vec = n_err;
    exp_rd  = model_read(a, n_err);
    exp_irq = |(full_ev(n_err) & m_mask);
    hw = '0;
    hw[3:0] = n_hp & ~p_hp;
    hw[26]  = n_gp & ~p_gp;
    hw[29]  = n_ge & ~p_ge;
    hw[27]  = gpio_fire(p_pin[0], n_pin[0], n_en[0], n_typ[1:0]);
    hw[28]  = gpio_fire(p_pin[1], n_pin[1], n_en[1], n_typ[3:2]);
    setv = (wr && a == 4'h0) ? (d & LM) : 32'h0;
    clrv = (wr && a == 4'h4) ? (d & LM) : 32'h0;
    @(posedge clk); #1;
    chk("R5 registered readback", bus_rdata, exp_rd);
    chk("R10 irq_out", {31'h0, irq_out}, {31'h0, exp_irq});
    m_ev = ((m_ev & ~clrv) | setv | hw) & LM;
    if (wr && a == 4'h8) m_mask = d & MM;
    p_hp = n_hp; p_gp = n_gp; p_ge = n_ge; p_pin = n_pin;
    bus_wr = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R11 reset rdata", bus_rdata, 32'h0);
    chk("R11 reset irq", {31'h0, irq_out}, 32'h0);
    @(negedge clk); rst = 1'b0;

    cyc(0, 4'h8, 0);
    chk("R11 mask after reset", bus_rdata, 32'h0);

    // R1: channel edges
    n_hp = 4'b0101; cyc(0, 4'h0, 0);
    cyc(0, 4'h0, 0);
    chk("R1 channel edges latch", bus_rdata, 32'h5);
    n_gp = 1; n_ge = 1; cyc(0, 4'h0, 0);
    cyc(0, 4'h0, 0);
    chk("R1 peripheral and error edges", bus_rdata, 32'h2400_0005);
    // R3: clear while sources stay high, no re-set
    cyc(1, 4'h4, 32'h2400_0005);
    cyc(0, 4'h0, 0);
    cyc(0, 4'h0, 0);
    chk("R3 clear while level held", bus_rdata, 32'h0);
    n_hp = 0; n_gp = 0; n_ge = 0; cyc(0, 4'h0, 0);

    // R2 and R6: set by write
    cyc(1, 4'h0, 32'hFFFF_FFFF);
    cyc(0, 4'h0, 0);
    chk("R2 set write", bus_rdata, 32'h3C00_000F);
    chk("R6 reserved bits zero", bus_rdata & 32'hBFFF_FFF0 & ~LM, 32'h0);
    cyc(1, 4'h0, 32'h0);
    cyc(0, 4'h0, 0);
    chk("R2 zero write no effect", bus_rdata, 32'h3C00_000F);
    cyc(1, 4'h4, 32'h0);
    cyc(0, 4'h0, 0);
    chk("R3 zero clear no effect", bus_rdata, 32'h3C00_000F);
    cyc(1, 4'h4, 32'h0000_0001);
    cyc(0, 4'h0, 0);
    chk("R3 single clear", bus_rdata, 32'h3C00_000E);
    cyc(1, 4'h4, 32'hFFFF_FFFF);

    // R4: edge with clear in same cycle
    n_hp = 4'b0100; cyc(1, 4'h4, 32'h0000_0004);
    cyc(0, 4'h0, 0);
    chk("R4 edge beats clear", bus_rdata, 32'h4);
    n_hp = 0;

    // R9, R5, R10
    cyc(1, 4'h8, 32'hFFFF_FFFF);
    cyc(0, 4'h8, 0);
    chk("R9 mask stored bits", bus_rdata, 32'h7C00_000F);
    chk("R10 irq high", {31'h0, irq_out}, 32'h1);
    cyc(1, 4'h8, 32'h0000_0002);
    cyc(0, 4'h4, 0);
    chk("R5 masked read", bus_rdata, 32'h0);
    cyc(0, 4'h0, 0);
    chk("R10 irq low when masked", {31'h0, irq_out}, 32'h0);

    // R7: live error bit
    n_err = 8'h10; cyc(0, 4'h0, 0);
    chk("R7 bit30 follows", bus_rdata, 32'h4000_0004);
    cyc(1, 4'h4, 32'h4000_0000);
    cyc(0, 4'h0, 0);
    chk("R7 clear ignored", bus_rdata, 32'h4000_0004);
    n_err = 0; cyc(1, 4'h0, 32'h4000_0000);
    cyc(0, 4'h0, 0);
    chk("R7 set ignored", bus_rdata, 32'h4);
    cyc(1, 4'h4, 32'hFFFF_FFFF);

    // R8: GPIO types
    n_en = 2'b11; n_typ = 4'b01_00; n_pin = 2'b11; cyc(0, 4'h0, 0);
    cyc(0, 4'h0, 0);
    chk("R8 pin0 rising only", bus_rdata, 32'h0800_0000);
    n_pin = 2'b00; cyc(0, 4'h0, 0);
    cyc(0, 4'h0, 0);
    chk("R8 pin1 falling", bus_rdata, 32'h1800_0000);
    cyc(1, 4'h4, 32'hFFFF_FFFF);
    n_typ = 4'b11_10; n_pin = 2'b11; cyc(0, 4'h0, 0);
    cyc(0, 4'h0, 0);
    chk("R8 both vs off", bus_rdata, 32'h0800_0000);
    cyc(1, 4'h4, 32'hFFFF_FFFF);
    n_en = 2'b00; n_typ = 4'b10_10; n_pin = 2'b00; cyc(0, 4'h0, 0);
    cyc(0, 4'h0, 0);
    chk("R8 disabled pins", bus_rdata, 32'h0);

    // R6: unmapped offset
    cyc(1, 4'hC, 32'hFFFF_FFFF);
    cyc(0, 4'hC, 0);
    chk("R6 unmapped reads zero", bus_rdata, 32'h0);

    // random phase
    void'($urandom(32'd1234));
    for (int k = 0; k < 3000; k++) begin
      logic [3:0] a;
      if ($urandom % 5 == 0) n_hp = n_hp ^ 4'($urandom);
      if ($urandom % 7 == 0) n_gp = ~n_gp;
      if ($urandom % 9 == 0) n_ge = ~n_ge;
      if ($urandom % 4 == 0) n_pin = 2'($urandom);
      if ($urandom % 50 == 0) begin n_en = 2'($urandom); n_typ = 4'($urandom); end
      n_err = ($urandom % 6 == 0) ? 8'($urandom) : 8'h0;
      a = 4'(($urandom % 4) * 4);
      cyc(($urandom % 3) == 0, a, $urandom);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule